// File: doc/BRIEF.md
# Double-Buffered Serial Byte Register

This block is the byte data path that sits between a processor's data-register port and a bit-level two-wire serial engine. It contains a transmit buffer, a receive buffer and one shift register shared by both directions. The processor writes outgoing bytes into the transmit buffer and reads incoming bytes from the receive buffer. Two flags report the buffer states: `tx_empty` says a new byte may be written, and `rx_full` says a received byte is waiting. Bytes move between the buffers and the shift register only at frame boundaries, and only when the flags allow it.

The serial engine steps the shift register with a one-cycle shift strobe. The register shifts toward its MSB, drives its MSB on `eng_sdo` and takes `eng_sdi` into its LSB. The engine closes each frame with a one-cycle frame-done strobe. In transmit mode that strobe reloads the shift register from a pending transmit byte. In receive mode it passes the received bits, LSB-justified, to the receive buffer. A frame may carry 1 to 8 data bits. Transmit bytes for short frames are written MSB-justified.

A small controller has two named states. In `ST_RUN` the shift register follows the strobes. The transition RUN→HOLD is taken when a receive frame ends while `rx_full` is still set. In `ST_HOLD` the shift register is frozen and strobes are ignored. The transition HOLD→RUN is taken in the first cycle in which `rx_full` is clear, and that same edge copies the held byte into the receive buffer.

Top module: `serdat_buf`

## Requirements
- R1: After reset the transmit buffer, receive buffer and shift register are 0, `tx_empty` is 1, `rx_full` is 0, `cpu_rdata` is 0 and `eng_sdo` is 0.
- R2: A cycle with `cpu_wr` high loads `cpu_wdata` into the transmit buffer and clears `tx_empty` at that edge. A second write before the byte is taken replaces it.
- R3: In transmit mode (`eng_tx_mode`=1), a frame-done strobe with `tx_empty`=0 copies the transmit buffer into the shift register and sets `tx_empty` at that edge. With `tx_empty`=1 the shift register keeps its value.
- R4: Each shift strobe in `ST_RUN` moves the shift register one place toward the MSB and takes `eng_sdi` into bit 0. `eng_sdo` is always bit 7. A byte therefore leaves MSB first, and a short frame sends the top N bits of the written byte.
- R5: In receive mode (`eng_tx_mode`=0), a frame-done strobe with `rx_full`=0 loads the low N bits of the shift register into the receive buffer, with the upper bits forced to 0, and sets `rx_full`. N is `eng_frame_bits`, and a value of 0 or above 8 is treated as 8.
- R6: `cpu_rdata` always shows the receive buffer. A cycle with `cpu_rd` high and `rx_full`=1 clears `rx_full` at that edge and leaves the data unchanged.
- R7: A receive frame-done strobe with `rx_full`=1 leaves the receive buffer unchanged and enters `ST_HOLD`. The masked byte is kept in the shift register. It moves to the receive buffer, setting `rx_full`, one edge after the read that cleared the flag.
- R8: In `ST_HOLD`, shift strobes and frame-done strobes are ignored, so `eng_sdo` stays unchanged.
- R9: When a shift strobe and a frame-done strobe arrive in the same cycle, the frame-done action is taken and the shift is dropped.
- R10: A transmit-mode frame-done strobe leaves `rx_full` and `cpu_rdata` unchanged. A receive-mode frame-done strobe leaves `tx_empty` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_wr | input | 1 | Write strobe for the transmit buffer |
| cpu_wdata | input | 8 | Byte to transmit (MSB-justified for short frames) |
| cpu_rd | input | 1 | Read strobe; consumes the received byte |
| cpu_rdata | output | 8 | Receive buffer contents |
| tx_empty | output | 1 | Transmit buffer may take a new byte |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| eng_tx_mode | input | 1 | 1 = transmit mode, 0 = receive mode |
| eng_frame_bits | input | 4 | Data bits per frame, 1 to 8 |
| eng_shift | input | 1 | One-cycle bit-shift strobe |
| eng_frame_done | input | 1 | One-cycle end-of-frame strobe |
| eng_sdi | input | 1 | Serial bit in |
| eng_sdo | output | 1 | Serial bit out (shift register MSB) |

## Verification
The assertions assume that the strobes are single-cycle pulses, that the engine keeps `eng_tx_mode` and `eng_frame_bits` steady across a frame, and that the processor reads only when it expects data. The stimulus changes every input on the falling clock edge and holds each strobe for one cycle only. Mode and frame length change only between frames. The bench drives the same-cycle shift/frame-done collision and the held-frame case on purpose, so the assertions on those paths are exercised with legal inputs.

// File: rtl/serdat_pkg.sv
package serdat_pkg;
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } hold_state_t;
endpackage

// File: rtl/serdat_txbuf.sv
module serdat_txbuf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         take,
    output logic [W-1:0] data,
    output logic         empty
);
    logic [W-1:0] data_q;
    logic         empty_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            empty_q <= 1'b1;
        end else begin
            if (wr) begin
                data_q  <= wdata;
                empty_q <= 1'b0;
            end else if (take) begin
                empty_q <= 1'b1;
            end
        end
    end

    assign data  = data_q;
    assign empty = empty_q;

    // R3: a byte is only taken when one is pending
    a_r3_take_pending: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !empty_q);
    // R3: taking the byte marks the buffer free
    a_r3_take_frees: assert property (@(posedge clk) disable iff (!rst_n)
        take && !wr |=> empty_q);
    // R2: a write always leaves a byte pending
    a_r2_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !empty_q && data_q == $past(wdata));
endmodule

// File: rtl/serdat_rxbuf.sv
module serdat_rxbuf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] ldata,
    input  logic         rd,
    output logic [W-1:0] data,
    output logic         full
);
    logic [W-1:0] data_q;
    logic         full_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            full_q <= 1'b0;
        end else begin
            if (load) begin
                data_q <= ldata;
                full_q <= 1'b1;
            end else if (rd) begin
                full_q <= 1'b0;
            end
        end
    end

    assign data = data_q;
    assign full = full_q;

    // R5: the buffer is only written while free
    a_r5_load_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !full_q);
    // R5: a load raises the full flag
    a_r5_load_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> full_q);
    // R6: a read of a full buffer frees it and keeps the data
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd && full_q |=> !full_q && $stable(data_q));
endmodule

// File: rtl/serdat_shifter.sv
module serdat_shifter #(
    parameter int W  = 8,
    parameter int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift,
    input  logic          sdi,
    input  logic          load,
    input  logic [W-1:0]  ldata,
    input  logic          mask_en,
    input  logic [CW-1:0] bits,
    output logic [W-1:0]  q,
    output logic [W-1:0]  masked,
    output logic          sdo
);
    logic [W-1:0]  sh_q;
    logic [CW-1:0] n_eff;
    logic [W-1:0]  keep;

    always_comb begin
        if (bits == '0 || bits > CW'(W)) n_eff = CW'(W);
        else                             n_eff = bits;
    end

    for (genvar i = 0; i < W; i++) begin : g_keep
        assign keep[i] = (CW'(i) < n_eff);
    end

    assign masked = sh_q & keep;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= ldata;
        end else if (mask_en) begin
            sh_q <= masked;
        end else if (shift) begin
            sh_q <= {sh_q[W-2:0], sdi};
        end
    end

    assign q   = sh_q;
    assign sdo = sh_q[W-1];

    // R4: a lone shift moves the register one place toward the MSB
    a_r4_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
        shift && !load && !mask_en |=> sh_q == {$past(sh_q[W-2:0]), $past(sdi)});
endmodule

// File: rtl/serdat_ctrl.sv
module serdat_ctrl
    import serdat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_mode,
    input  logic frame_done,
    input  logic shift,
    input  logic tx_empty,
    input  logic rx_full,
    output logic tx_take,
    output logic rx_load,
    output logic rx_from_mask,
    output logic sh_shift,
    output logic sh_mask,
    output logic hold
);
    hold_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d      = state_q;
        tx_take      = 1'b0;
        rx_load      = 1'b0;
        rx_from_mask = 1'b0;
        sh_shift     = 1'b0;
        sh_mask      = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (frame_done) begin
                    if (tx_mode) begin
                        tx_take = !tx_empty;
                    end else begin
                        sh_mask = 1'b1;
                        if (!rx_full) begin
                            rx_load      = 1'b1;
                            rx_from_mask = 1'b1;
                        end else begin
                            state_d = ST_HOLD;
                        end
                    end
                end else if (shift) begin
                    sh_shift = 1'b1;
                end
            end
            ST_HOLD: begin
                if (!rx_full) begin
                    rx_load = 1'b1;
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    assign hold = (state_q == ST_HOLD);

    // R7: a held byte is released as soon as the buffer is free
    a_r7_hold_release: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_HOLD && !rx_full |=> state_q == ST_RUN);
    // R7: a receive frame ending on a full buffer enters hold
    a_r7_hold_entry: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_RUN && frame_done && !tx_mode && rx_full |=> state_q == ST_HOLD);
    // R9: never shift and end a frame in the same cycle
    a_r9_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        !(sh_shift && (tx_take || sh_mask)));
endmodule

// File: rtl/serdat_buf.sv
module serdat_buf #(
    parameter  int DATA_W = 8,
    localparam int CNT_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_rd,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              tx_empty,
    output logic              rx_full,
    input  logic              eng_tx_mode,
    input  logic [CNT_W-1:0]  eng_frame_bits,
    input  logic              eng_shift,
    input  logic              eng_frame_done,
    input  logic              eng_sdi,
    output logic              eng_sdo
);
    logic              tx_take, rx_load, rx_from_mask, sh_shift, sh_mask, hold;
    logic [DATA_W-1:0] tx_data, sh_q, sh_masked, rx_ldata;

    serdat_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_mode      (eng_tx_mode),
        .frame_done   (eng_frame_done),
        .shift        (eng_shift),
        .tx_empty     (tx_empty),
        .rx_full      (rx_full),
        .tx_take      (tx_take),
        .rx_load      (rx_load),
        .rx_from_mask (rx_from_mask),
        .sh_shift     (sh_shift),
        .sh_mask      (sh_mask),
        .hold         (hold)
    );

    serdat_txbuf #(.W(DATA_W)) u_txbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cpu_wr),
        .wdata (cpu_wdata),
        .take  (tx_take),
        .data  (tx_data),
        .empty (tx_empty)
    );

    serdat_shifter #(.W(DATA_W), .CW(CNT_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift   (sh_shift),
        .sdi     (eng_sdi),
        .load    (tx_take),
        .ldata   (tx_data),
        .mask_en (sh_mask),
        .bits    (eng_frame_bits),
        .q       (sh_q),
        .masked  (sh_masked),
        .sdo     (eng_sdo)
    );

    assign rx_ldata = rx_from_mask ? sh_masked : sh_q;

    serdat_rxbuf #(.W(DATA_W)) u_rxbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (rx_load),
        .ldata (rx_ldata),
        .rd    (cpu_rd),
        .data  (cpu_rdata),
        .full  (rx_full)
    );

    // R8: the shift register is frozen while a byte is held
    a_r8_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(sh_q));
    // R10: a transmit frame end leaves the receive side alone
    a_r10_tx_keeps_rx: assert property (@(posedge clk) disable iff (!rst_n)
        eng_frame_done && eng_tx_mode && !cpu_rd && !hold |=> $stable(rx_full) && $stable(cpu_rdata));
    // R10: a receive frame end leaves the transmit flag alone
    a_r10_rx_keeps_tx: assert property (@(posedge clk) disable iff (!rst_n)
        eng_frame_done && !eng_tx_mode && !cpu_wr |=> $stable(tx_empty));
endmodule

// File: tb/serdat_buf_bench.sv
module serdat_buf_bench;
    localparam int CLK_NS = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       tx_empty, rx_full;
    logic       eng_tx_mode = 1'b1;
    logic [3:0] eng_frame_bits = 4'd8;
    logic       eng_shift = 1'b0, eng_frame_done = 1'b0, eng_sdi = 1'b0;
    logic       eng_sdo;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_NS/2) clk = ~clk;

    serdat_buf u_serdat_buf (
        .clk            (clk),
        .rst_n          (rst_n),
        .cpu_wr         (cpu_wr),
        .cpu_wdata      (cpu_wdata),
        .cpu_rd         (cpu_rd),
        .cpu_rdata      (cpu_rdata),
        .tx_empty       (tx_empty),
        .rx_full        (rx_full),
        .eng_tx_mode    (eng_tx_mode),
        .eng_frame_bits (eng_frame_bits),
        .eng_shift      (eng_shift),
        .eng_frame_done (eng_frame_done),
        .eng_sdi        (eng_sdi),
        .eng_sdo        (eng_sdo)
    );

    // driver side: queue what the requirements predict
    task automatic expect_val(input string tag, input logic [7:0] v);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    // monitor side: pop the prediction and compare with what was seen
    task automatic observe(input logic [7:0] actual);
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (actual !== e) begin
            errors++;
            $display("FAIL %s actual %h expected %h", t, actual, e);
        end
    endtask

    task automatic chk(input string tag, input logic [7:0] actual, input logic [7:0] e);
        expect_val(tag, e);
        observe(actual);
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic cpu_write(input logic [7:0] v);
        cpu_wr = 1'b1; cpu_wdata = v; cyc(); cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(output logic [7:0] v);
        v = cpu_rdata; cpu_rd = 1'b1; cyc(); cpu_rd = 1'b0;
    endtask

    task automatic shift_bit(input logic b);
        eng_sdi = b; eng_shift = 1'b1; cyc(); eng_shift = 1'b0;
    endtask

    task automatic end_frame();
        eng_frame_done = 1'b1; cyc(); eng_frame_done = 1'b0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_NS * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog actual hung expected finished");
        finish_run();
    end

    initial begin
        logic [7:0] rv;
        logic [7:0] pat;
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        chk("R1 rdata", cpu_rdata, 8'h00);
        chk("R1 tx_empty", {7'd0, tx_empty}, 8'h01);
        chk("R1 rx_full", {7'd0, rx_full}, 8'h00);
        chk("R1 sdo", {7'd0, eng_sdo}, 8'h00);

        // R2 write and overwrite
        cpu_write(8'hA5);
        chk("R2 empty cleared", {7'd0, tx_empty}, 8'h00);
        cpu_write(8'h3C);
        chk("R2 still pending", {7'd0, tx_empty}, 8'h00);

        // R3 transfer into shift register, R4 MSB first
        eng_tx_mode = 1'b1;
        end_frame();
        chk("R3 empty set", {7'd0, tx_empty}, 8'h01);
        pat = 8'h3C;
        for (int i = 7; i >= 0; i--) begin
            expect_val("R4 tx bit", {7'd0, pat[i]});
            observe({7'd0, eng_sdo});
            shift_bit(1'b1);
        end
        // after 8 shifts of 1s register is all ones
        end_frame();
        chk("R3 no pending keeps shreg", {7'd0, eng_sdo}, 8'h01);
        chk("R3 no pending keeps empty", {7'd0, tx_empty}, 8'h01);

        // R4 short frame, MSB-justified
        cpu_write(8'hA0);
        eng_frame_bits = 4'd3;
        end_frame();
        pat = 8'hA0;
        for (int i = 7; i >= 5; i--) begin
            expect_val("R4 short tx bit", {7'd0, pat[i]});
            observe({7'd0, eng_sdo});
            shift_bit(1'b0);
        end

        // R10 pending tx byte survives receive frames
        cpu_write(8'h81);
        eng_tx_mode = 1'b0;
        eng_frame_bits = 4'd8;
        pat = 8'h96;
        for (int i = 7; i >= 0; i--) shift_bit(pat[i]);
        end_frame();
        chk("R5 full set", {7'd0, rx_full}, 8'h01);
        chk("R5 byte", cpu_rdata, 8'h96);
        chk("R10 tx_empty kept", {7'd0, tx_empty}, 8'h00);

        // R6 read clears flag, data stays
        cpu_read(rv);
        chk("R6 read value", rv, 8'h96);
        chk("R6 full cleared", {7'd0, rx_full}, 8'h00);
        chk("R6 data kept", cpu_rdata, 8'h96);

        // R5 short receive frame: LSB-justified, upper bits zero
        eng_frame_bits = 4'd5;
        shift_bit(1'b1); shift_bit(1'b0); shift_bit(1'b1);
        shift_bit(1'b1); shift_bit(1'b0);
        end_frame();
        chk("R5 short rx", cpu_rdata, 8'h16);

        // R7 frame ends while full: hold
        eng_frame_bits = 4'd8;
        pat = 8'h5A;
        for (int i = 7; i >= 0; i--) shift_bit(pat[i]);
        end_frame();
        chk("R7 buffer untouched", cpu_rdata, 8'h16);
        chk("R7 still full", {7'd0, rx_full}, 8'h01);
        // R8 strobes ignored while held
        shift_bit(1'b1);
        shift_bit(1'b1);
        chk("R8 sdo frozen", {7'd0, eng_sdo}, 8'h00);
        end_frame();
        chk("R8 buffer untouched", cpu_rdata, 8'h16);
        cpu_read(rv);
        chk("R7 read old byte", rv, 8'h16);
        chk("R7 flag low after read", {7'd0, rx_full}, 8'h00);
        cyc();
        chk("R7 held byte delivered", cpu_rdata, 8'h5A);
        chk("R7 flag back", {7'd0, rx_full}, 8'h01);

        // R9 simultaneous strobes: frame end wins; R10 rx side untouched
        eng_tx_mode = 1'b1;
        eng_sdi = 1'b1; eng_shift = 1'b1; eng_frame_done = 1'b1;
        cyc();
        eng_shift = 1'b0; eng_frame_done = 1'b0;
        chk("R9 transfer taken", {7'd0, tx_empty}, 8'h01);
        chk("R9 shift dropped", {7'd0, eng_sdo}, 8'h01);
        chk("R10 rx_full kept", {7'd0, rx_full}, 8'h01);
        chk("R10 rdata kept", cpu_rdata, 8'h5A);
        shift_bit(1'b0);
        chk("R4 next bit after load", {7'd0, eng_sdo}, 8'h00);

        finish_run();
    end
endmodule